// File: doc/BRIEF.md
# Local Interrupt Controller Base Register and Mode Controller

This block holds the 64-bit base register of a local interrupt controller. It also decides which of three operating modes the controller is in: off, legacy (xAPIC) or extended (x2APIC). Software writes a new register value through a valid/ready port. The block checks the value against the current mode and the extended-mode capability strap. It then either commits the value or drops it and raises a one-cycle error pulse.

When a commit enters or re-asserts extended mode, the block loads a logical destination register. That value is computed from the initial controller ID. The block also owns three small pieces of state that the mode changes affect: the controller ID register, the software-enable bit of the spurious vector register, and a feature-enable flag.

The write port never applies back-pressure. `wr_ready` is high in every cycle, so a write is taken in any cycle where `wr_valid` is high. All results appear on the outputs one clock after that cycle.

Top module: `apic_base_ctrl`

## Requirements
- R1: After reset, the register reads `0x00000000_FEE00800` with bit 8 copied from `bsp_strap`. `mode` reads 01, `feat_en` is 1, `spur_en` is 0, `ldr` is 0 and `apic_id` equals `init_id`.
- R2: `mode` is {bit 10, bit 11} of the register: 00 is off, 01 is xAPIC, 11 is x2APIC. The value 10 never appears.
- R3: The register layout is: bit 8 holds the bootstrap-processor flag, bit 10 the extended flag, bit 11 the enable flag, and bits 31:12 the base address. Every other bit reads 0.
- R4: A write with bit 10 set is rejected while `x2_cap` is low.
- R5: A write with bit 10 set and bit 11 clear is rejected.
- R6: A write with bits 11 and 10 both set is rejected while the mode is off.
- R7: A write with bit 11 set and bit 10 clear is rejected while the mode is x2APIC.
- R8: A rejected write changes nothing except the ID register (see R11). `wr_err` is high for exactly the one cycle after the write.
- R9: An accepted write takes bits 31:12 as the base and bits 11 and 10 as the enable and extended flags. It keeps the bootstrap flag. `feat_en` follows the enable flag, and `wr_err` stays low.
- R10: An accepted write with bit 10 set loads `ldr` with `init_id[15:4]` in bits 31:20 and a one-hot bit at position `init_id[3:0]`. All other bits of `ldr` are 0.
- R11: Every write, accepted or rejected, reloads `apic_id` from `init_id`. Otherwise, `id_load` loads `id_value`. A write wins over `id_load` in the same cycle.
- R12: An accepted write with bit 11 clear clears `spur_en`. Otherwise, `spur_set` sets `spur_en`.
- R13: `wr_ready` is always high, and every result of a write is visible on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bsp_strap | input | 1 | Bootstrap-processor strap sampled at reset |
| x2_cap | input | 1 | Extended-mode capability |
| init_id | input | 32 | Initial controller ID |
| wr_valid | input | 1 | Register write request |
| wr_ready | output | 1 | Write accepted (always 1) |
| wr_data | input | 64 | Value to write |
| wr_err | output | 1 | Write rejected, one-cycle pulse |
| id_load | input | 1 | Load controller ID |
| id_value | input | 32 | New controller ID |
| spur_set | input | 1 | Set spurious software-enable |
| base_reg | output | 64 | Current register value |
| base_addr | output | 20 | Base address field |
| mode | output | 2 | Operating mode |
| feat_en | output | 1 | Feature-enable flag |
| apic_id | output | 32 | Controller ID register |
| ldr | output | 32 | Logical destination register |
| spur_en | output | 1 | Spurious software-enable bit |

## Verification
The assertions check the following on every cycle:
- The mode never takes the value 10.
- The mode never moves directly from off to x2APIC, or from x2APIC to xAPIC.
- A write without the capability always yields an error pulse.
- The register is stable in any cycle that carries an error.
- The ID register is restored after each write.
- A falling feature flag leaves the spurious enable clear.

The bench's scenarios show what needs a model of the whole history:
- the exact committed base and flag values;
- the `ldr` value computed from the ID;
- the priority of a write over `id_load` and `spur_set`;
- that a rejection keeps every other output intact.

// File: rtl/apic_base_pkg.sv
package apic_base_pkg;
  localparam int REG_W    = 64;
  localparam int BSP_BIT  = 8;
  localparam int EXT_BIT  = 10;
  localparam int EN_BIT   = 11;
  localparam int BASE_LSB = 12;
  localparam int BASE_MSB = 31;
  localparam int BASE_W   = BASE_MSB - BASE_LSB + 1;
  localparam int ID_W     = 32;
  localparam int LDR_W    = 32;

  typedef enum logic [1:0] {
    MODE_OFF   = 2'b00,
    MODE_XAPIC = 2'b01,
    MODE_X2    = 2'b11
  } mode_e;

  typedef struct packed {
    logic ext;
    logic en;
  } ctl_t;
endpackage

// File: rtl/apic_xfer_check.sv
module apic_xfer_check
  import apic_base_pkg::*;
(
  input  ctl_t cur,
  input  ctl_t req,
  input  logic cap,
  output logic reject
);
  logic no_cap, ext_no_en, off_to_x2, x2_to_x;

  always_comb begin
    no_cap    = req.ext && !cap;
    ext_no_en = req.ext && !req.en;
    off_to_x2 = !cur.en && !cur.ext && req.en && req.ext;
    x2_to_x   = cur.en && cur.ext && req.en && !req.ext;
    reject    = no_cap || ext_no_en || off_to_x2 || x2_to_x;
  end
endmodule

// File: rtl/apic_ldr_calc.sv
module apic_ldr_calc
  import apic_base_pkg::*;
#(
  parameter int CL_LSB  = 4,
  parameter int CL_W    = 12,
  parameter int OH_W    = 16,
  localparam int SEL_W  = $clog2(OH_W),
  localparam int GAP_W  = LDR_W - CL_W - OH_W
) (
  input  logic [ID_W-1:0]  id,
  output logic [LDR_W-1:0] ldr
);
  logic [OH_W-1:0] onehot;
  logic [CL_W-1:0] cluster;
  logic            unused_hi;

  assign cluster   = id[CL_LSB +: CL_W];
  assign unused_hi = ^id[ID_W-1:CL_LSB+CL_W];

  for (genvar g = 0; g < OH_W; g++) begin : g_oh
    assign onehot[g] = (id[SEL_W-1:0] == SEL_W'(g));
  end

  assign ldr = {cluster, {GAP_W{1'b0}}, onehot};
endmodule

// File: rtl/apic_base_ctrl.sv
module apic_base_ctrl
  import apic_base_pkg::*;
#(
  parameter logic [BASE_W-1:0] RESET_BASE = 20'hFEE00
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bsp_strap,
  input  logic              x2_cap,
  input  logic [ID_W-1:0]   init_id,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [REG_W-1:0]  wr_data,
  output logic              wr_err,
  input  logic              id_load,
  input  logic [ID_W-1:0]   id_value,
  input  logic              spur_set,
  output logic [REG_W-1:0]  base_reg,
  output logic [BASE_W-1:0] base_addr,
  output logic [1:0]        mode,
  output logic              feat_en,
  output logic [ID_W-1:0]   apic_id,
  output logic [LDR_W-1:0]  ldr,
  output logic              spur_en
);
  localparam int HI_W = REG_W - BASE_MSB - 1;

  logic [BASE_W-1:0] base_q;
  ctl_t              ctl_q;
  logic              bsp_q;
  logic [LDR_W-1:0]  ldr_q;
  logic [ID_W-1:0]   id_q;
  logic              spur_q;
  logic              err_q;

  ctl_t              req;
  logic              wr_fire;
  logic              reject;
  logic              commit;
  logic [LDR_W-1:0]  ldr_new;
  logic              unused_wr;

  assign wr_ready  = 1'b1;
  assign wr_fire   = wr_valid && wr_ready;
  assign req.en    = wr_data[EN_BIT];
  assign req.ext   = wr_data[EXT_BIT];
  assign commit    = wr_fire && !reject;
  assign unused_wr = ^{wr_data[REG_W-1:BASE_MSB+1], wr_data[EXT_BIT-1:0]};

  apic_xfer_check u_check (
    .cur    (ctl_q),
    .req    (req),
    .cap    (x2_cap),
    .reject (reject)
  );

  apic_ldr_calc u_ldr (
    .id  (init_id),
    .ldr (ldr_new)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q  <= RESET_BASE;
      ctl_q   <= '{ext: 1'b0, en: 1'b1};
      bsp_q   <= bsp_strap;
      ldr_q   <= '0;
      id_q    <= init_id;
      spur_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      err_q <= wr_fire && reject;

      if (wr_fire)      id_q <= init_id;
      else if (id_load) id_q <= id_value;

      if (commit) begin
        base_q <= wr_data[BASE_MSB:BASE_LSB];
        ctl_q  <= req;
        if (req.ext) ldr_q <= ldr_new;
      end

      if (commit && !req.en) spur_q <= 1'b0;
      else if (spur_set)     spur_q <= 1'b1;
    end
  end

  assign wr_err    = err_q;
  assign base_addr = base_q;
  assign mode      = {ctl_q.ext, ctl_q.en};
  assign feat_en   = ctl_q.en;
  assign apic_id   = id_q;
  assign ldr       = ldr_q;
  assign spur_en   = spur_q;

  always_comb begin
    base_reg                     = '0;
    base_reg[BASE_MSB:BASE_LSB]  = base_q;
    base_reg[EN_BIT]             = ctl_q.en;
    base_reg[EXT_BIT]            = ctl_q.ext;
    base_reg[BSP_BIT]            = bsp_q;
    base_reg[REG_W-1 -: HI_W]    = '0;
  end
endmodule

module apic_base_ctrl_chk
  import apic_base_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              x2_cap,
  input logic [ID_W-1:0]   init_id,
  input logic              wr_valid,
  input logic              wr_ready,
  input logic [REG_W-1:0]  wr_data,
  input logic              wr_err,
  input logic [REG_W-1:0]  base_reg,
  input logic [1:0]        mode,
  input logic              feat_en,
  input logic [ID_W-1:0]   apic_id,
  input logic              spur_en
);
  logic fire;
  assign fire = wr_valid && wr_ready;

  a_r2_no_mode_10: assert property (@(posedge clk) disable iff (!rst_n)
    mode != 2'b10);

  a_r4_ext_needs_cap: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && wr_data[EXT_BIT] && !x2_cap) |=> wr_err);

  a_r6_no_off_to_x2: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b11) |-> ($past(mode) != 2'b00));

  a_r7_no_x2_to_xapic: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b01) |-> ($past(mode) != 2'b11));

  a_r8_reject_holds: assert property (@(posedge clk) disable iff (!rst_n)
    wr_err |-> $stable(base_reg));

  a_r11_id_restore: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> (apic_id == $past(init_id)));

  a_r12_disable_clears_spur: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(feat_en) |-> !spur_en);

  a_r13_always_ready: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ready);
endmodule

bind apic_base_ctrl apic_base_ctrl_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .x2_cap   (x2_cap),
  .init_id  (init_id),
  .wr_valid (wr_valid),
  .wr_ready (wr_ready),
  .wr_data  (wr_data),
  .wr_err   (wr_err),
  .base_reg (base_reg),
  .mode     (mode),
  .feat_en  (feat_en),
  .apic_id  (apic_id),
  .spur_en  (spur_en)
);

// File: tb/test_apic_base_ctrl.sv
`timescale 1ns/1ps
module test_apic_base_ctrl;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        bsp_strap = 1;
  logic        x2_cap = 1;
  logic [31:0] init_id = 32'h0001_2345;
  logic        wr_valid = 0;
  logic        wr_ready;
  logic [63:0] wr_data = '0;
  logic        wr_err;
  logic        id_load = 0;
  logic [31:0] id_value = '0;
  logic        spur_set = 0;
  logic [63:0] base_reg;
  logic [19:0] base_addr;
  logic [1:0]  mode;
  logic        feat_en;
  logic [31:0] apic_id;
  logic [31:0] ldr;
  logic        spur_en;

  int total = 0;
  int bad = 0;
  bit done = 0;

  logic [19:0] m_base;
  logic        m_en, m_ext, m_bsp, m_spur, m_err;
  logic [31:0] m_ldr, m_id;

  always #10 clk = ~clk;

  apic_base_ctrl i_apic_base_ctrl (
    .clk(clk), .rst_n(rst_n), .bsp_strap(bsp_strap), .x2_cap(x2_cap),
    .init_id(init_id), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_data(wr_data), .wr_err(wr_err), .id_load(id_load),
    .id_value(id_value), .spur_set(spur_set), .base_reg(base_reg),
    .base_addr(base_addr), .mode(mode), .feat_en(feat_en),
    .apic_id(apic_id), .ldr(ldr), .spur_en(spur_en)
  );

  function automatic logic [31:0] ldr_of(input logic [31:0] id);
    logic [31:0] v;
    v = (id & 32'h000F_FFF0) << 16;
    v = v | (32'd1 << id[3:0]);
    return v;
  endfunction

  function automatic string why_reject(input logic en, input logic ext,
                                      input logic [63:0] v, input logic cap);
    if (v[10] && !cap) return "R4";
    if (v[10] && !v[11]) return "R5";
    if (!en && !ext && v[11] && v[10]) return "R6";
    if (en && ext && v[11] && !v[10]) return "R7";
    return "";
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check_all(input string err_tag);
    check("R3", base_reg, {32'h0, m_base, m_en, m_ext, 1'b0, m_bsp, 8'h00});
    check("R9", {44'h0, base_addr}, {44'h0, m_base});
    check("R2", {62'h0, mode}, {62'h0, m_ext, m_en});
    check("R9", {63'h0, feat_en}, {63'h0, m_en});
    check(err_tag, {63'h0, wr_err}, {63'h0, m_err});
    check("R10", {32'h0, ldr}, {32'h0, m_ldr});
    check("R11", {32'h0, apic_id}, {32'h0, m_id});
    check("R12", {63'h0, spur_en}, {63'h0, m_spur});
    check("R13", {63'h0, wr_ready}, 64'h1);
  endtask

  // one cycle of stimulus; model updated, outputs checked after the edge
  task automatic cycle(input logic wv, input logic [63:0] wd,
                       input logic il, input logic [31:0] iv, input logic ss);
    string tag, r;
    logic acc;
    wr_valid = wv; wr_data = wd; id_load = il; id_value = iv; spur_set = ss;
    r = why_reject(m_en, m_ext, wd, x2_cap);
    acc = wv && (r == "");
    m_err = wv && (r != "");
    tag = m_err ? r : "R8";
    if (wv) m_id = init_id;
    else if (il) m_id = iv;
    if (acc) begin
      m_base = wd[31:12];
      m_en = wd[11];
      m_ext = wd[10];
      if (wd[10]) m_ldr = ldr_of(init_id);
    end
    if (acc && !wd[11]) m_spur = 0;
    else if (ss) m_spur = 1;
    @(posedge clk);
    @(negedge clk);
    wr_valid = 0; id_load = 0; spur_set = 0;
    check_all(tag);
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  function automatic logic [63:0] wv(input logic [19:0] b, input logic en, input logic ext);
    return {32'hDEAD_BEEF, b, en, ext, 2'b11, 8'h5A};
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_up();
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    m_base = 20'hFEE00; m_en = 1; m_ext = 0; m_bsp = 1; m_spur = 0;
    m_err = 0; m_ldr = 0; m_id = init_id;
    check_all("R1");

    // R11: id_load then write restores
    cycle(0, '0, 1, 32'hAAAA_5555, 0);
    cycle(1, wv(20'h12345, 1, 0), 1, 32'h1111_2222, 0);
    // R4: ext without capability
    x2_cap = 0;
    cycle(1, wv(20'h11111, 1, 1), 0, 0, 0);
    check("R4", {63'h0, wr_err}, 64'h1);
    x2_cap = 1;
    // R8: err lasts one cycle
    cycle(0, '0, 0, 0, 0);
    check("R8", {63'h0, wr_err}, 64'h0);
    // R5: ext with enable clear
    cycle(1, wv(20'h22222, 0, 1), 0, 0, 0);
    // R10: enter x2
    init_id = 32'h000A_BC37;
    cycle(1, wv(20'h33333, 1, 1), 0, 0, 1);
    check("R10", {32'h0, ldr}, {32'h0, 12'hBC3, 4'h0, 16'h0080});
    // R7: x2 to xAPIC
    cycle(1, wv(20'h44444, 1, 0), 0, 0, 0);
    // R12: disable clears spur even with spur_set
    cycle(1, wv(20'h55555, 0, 0), 0, 0, 1);
    // R6: off to x2
    cycle(1, wv(20'h66666, 1, 1), 0, 0, 0);
    // R9: off to xAPIC
    cycle(1, wv(20'h77777, 1, 0), 0, 0, 1);

    for (int i = 0; i < 600; i++) begin
      int op;
      op = $urandom_range(0, 9);
      if (op == 0) x2_cap = $urandom_range(0, 1);
      if (op == 1) init_id = $urandom;
      if (op < 6) begin
        logic [63:0] d;
        d = {$urandom, $urandom};
        cycle(1, d, $urandom_range(0, 1), $urandom, $urandom_range(0, 1));
      end else begin
        cycle(0, '0, $urandom_range(0, 1), $urandom, $urandom_range(0, 1));
      end
    end
    finish_up();
  end
endmodule